// File: doc/BRIEF.md
# Host Port I/O Bus Cycle Sequencer

This block is the processor-side engine that runs port input and port output cycles on a simple 8-bit parallel expansion bus. A request arrives on a ready/valid handshake with a port number, a direction and, for writes, a data byte. For a write, the block puts the port number and the data on the bus and raises the output strobe in the same clock. For a read, it puts the port number on the bus, waits a set number of cycles, samples the peripheral's wait line, raises the input strobe and captures the data bus at the end of the strobe.

The wait line is only looked at just before the input strobe rises. If it was seen asserted, the input strobe is not stretched. The block drops it, keeps it low for a short gap, samples wait again and fires a fresh strobe with a fresh capture. This repeats until wait is seen low, and the byte captured on that last strobe is the result. Every width and delay is a parameter counted in clocks. At a 10 ns clock the defaults give a 940 ns output strobe, 250 ns from address to input strobe, and a 3.19 µs input strobe.

A halt request raises a status line that stays low during ordinary I/O cycles. The block then takes no further requests until reset. Peripherals typically decode the upper six address bits (all ones selects ports 252 to 255) and use the low two bits to pick a register. For that to work, the address has to stay fixed for the whole cycle.

Top module: `hiobus_seq`

## Requirements
- R1: `req_ready` is high only when no cycle is in progress and no halt is pending; a request held on `req_valid` while the block is busy is not taken until the cycle in progress completes, and is accepted at the next edge after that.
- R2: On a write, `bus_addr`, `bus_dout` and `bus_out_stb` all change at the edge that accepts the request, the same edge at which `busy` rises (no setup gap).
- R3: The output strobe is active high and stays high for exactly `OUT_PULSE` clock cycles.
- R4: On a read, `bus_in_stb` rises exactly `IN_SETUP` clock cycles after the edge that drives `bus_addr`.
- R5: Every input strobe stays high for exactly `IN_PULSE` clock cycles.
- R6: `bus_wait_in` is sampled at the edge that raises the input strobe. If it was high, the strobe is released after its width, stays low for `IN_GAP` cycles, and wait is sampled again with a new strobe. A read therefore produces one strobe more than the number of consecutive high wait samples.
- R7: `bus_din` is captured at the last cycle of each input strobe, and `rd_data` after the read ends holds the byte present on the final strobe.
- R8: `busy` is high from the accepting edge until the cycle ends. `done` is a one-cycle pulse in the first cycle with `busy` low, and for reads `rd_data` is valid then.
- R9: `bus_halt` is low during I/O cycles. After `halt_req` is seen while idle, it is high two edges later. It stays high, and requests are refused, until reset.
- R10: During and right after reset: both strobes low, `busy`, `done` and `bus_halt` low, `bus_addr` and `rd_data` zero, `req_ready` high.
- R11: `bus_addr` does not change while a cycle is in progress, the two strobes are never high together, and neither strobe is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A port request is offered |
| req_ready | output | 1 | Block can take a request this cycle |
| req_is_read | input | 1 | 1 = port read, 0 = port write |
| req_port | input | ADDR_W | Port number for the request |
| req_wdata | input | DATA_W | Byte to write |
| halt_req | input | 1 | Enter halt after any cycle in progress |
| busy | output | 1 | An I/O cycle is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Byte returned by the last read |
| bus_addr | output | ADDR_W | Port address on the bus |
| bus_dout | output | DATA_W | Write data on the bus |
| bus_din | input | DATA_W | Read data from the bus |
| bus_out_stb | output | 1 | Output strobe, active high |
| bus_in_stb | output | 1 | Input strobe, active high |
| bus_wait_in | input | 1 | Peripheral wait request |
| bus_halt | output | 1 | Wait/status line, high once halted |

## Verification
The bench drives inputs and reads outputs on falling clock edges, so an accepted request shows up at the very next sample. A write's address, data and strobe appear there together. A read shows its address there, and its strobe after exactly `IN_SETUP` more low samples. Widths and gaps are counted in samples taken while a strobe is high or low, and `done` is expected in the same sample as the final strobe's fall. A halt is expected two samples after `halt_req` is applied. The peripheral model inside the read task changes wait and data in the sample where it sees a strobe fall. That is always at least one edge before the next wait sample, which leaves the expected pulse count and final byte unambiguous.

// File: rtl/hiobus_pkg.sv
`timescale 1ns/1ps
package hiobus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_STB,
    ST_RD_SETUP,
    ST_RD_STB,
    ST_RD_GAP,
    ST_HALT
  } seq_state_t;

  // Countdown start value for an interval of the given length in cycles.
  function automatic int unsigned span_to_load(int unsigned cycles);
    return (cycles == 0) ? 0 : cycles - 1;
  endfunction

  // Counter width large enough for the longest of four intervals.
  function automatic int unsigned span_width(int unsigned a, int unsigned b,
                                             int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return ($clog2(m) < 1) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/hiobus_timer.sv
`timescale 1ns/1ps
module hiobus_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/hiobus_ctrl.sv
`timescale 1ns/1ps
module hiobus_ctrl #(
  parameter int CNT_W     = 9,
  parameter int OUT_PULSE = 94,
  parameter int IN_SETUP  = 25,
  parameter int IN_PULSE  = 319,
  parameter int IN_GAP    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_is_read,
  input  logic             halt_req,
  input  logic             bus_wait_in,
  input  logic             tmr_zero,
  output logic             req_ready,
  output logic             accept,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             out_stb,
  output logic             in_stb,
  output logic             capture,
  output logic             done,
  output logic             busy,
  output logic             halted,
  output logic             wait_sample,
  output logic             wait_seen
);
  import hiobus_pkg::*;

  localparam logic [CNT_W-1:0] LD_OUT   = CNT_W'(span_to_load(OUT_PULSE));
  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(span_to_load(IN_SETUP));
  localparam logic [CNT_W-1:0] LD_IN    = CNT_W'(span_to_load(IN_PULSE));
  localparam logic [CNT_W-1:0] LD_GAP   = CNT_W'(span_to_load(IN_GAP));

  seq_state_t state_q, state_d;
  logic       out_d, in_d, done_d, halt_pend_q;

  assign req_ready = (state_q == ST_IDLE) && !halt_pend_q;
  assign accept    = req_valid && req_ready;
  assign busy      = (state_q == ST_WR_STB) || (state_q == ST_RD_SETUP) ||
                     (state_q == ST_RD_STB) || (state_q == ST_RD_GAP);
  assign halted    = (state_q == ST_HALT);
  assign capture   = (state_q == ST_RD_STB) && tmr_zero;

  always_comb begin
    state_d     = state_q;
    out_d       = out_stb;
    in_d        = in_stb;
    done_d      = 1'b0;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    wait_sample = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (halt_pend_q) begin
          state_d = ST_HALT;
        end else if (accept) begin
          tmr_load = 1'b1;
          if (req_is_read) begin
            state_d = ST_RD_SETUP;
            tmr_val = LD_SETUP;
          end else begin
            state_d = ST_WR_STB;
            out_d   = 1'b1;
            tmr_val = LD_OUT;
          end
        end
      end
      ST_WR_STB: begin
        if (tmr_zero) begin
          out_d   = 1'b0;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_RD_SETUP, ST_RD_GAP: begin
        if (tmr_zero) begin
          wait_sample = 1'b1;
          in_d        = 1'b1;
          tmr_load    = 1'b1;
          tmr_val     = LD_IN;
          state_d     = ST_RD_STB;
        end
      end
      ST_RD_STB: begin
        if (tmr_zero) begin
          in_d = 1'b0;
          if (wait_seen) begin
            tmr_load = 1'b1;
            tmr_val  = LD_GAP;
            state_d  = ST_RD_GAP;
          end else begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      out_stb     <= 1'b0;
      in_stb      <= 1'b0;
      done        <= 1'b0;
      wait_seen   <= 1'b0;
      halt_pend_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      out_stb     <= out_d;
      in_stb      <= in_d;
      done        <= done_d;
      halt_pend_q <= halt_pend_q | halt_req;
      if (wait_sample) wait_seen <= bus_wait_in;
    end
  end

endmodule

// File: rtl/hiobus_dpath.sv
`timescale 1ns/1ps
module hiobus_dpath #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_is_read,
  input  logic [ADDR_W-1:0] req_port,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] bus_din,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr <= '0;
      bus_dout <= '0;
    end else if (accept) begin
      bus_addr <= req_port;
      if (!req_is_read) bus_dout <= req_wdata;
    end
  end

  // Each strobe overwrites the result; the final strobe's byte remains.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data <= '0;
    else if (capture) rd_data <= bus_din;
  end

endmodule

// File: rtl/hiobus_seq.sv
`timescale 1ns/1ps
module hiobus_seq #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int OUT_PULSE = 94,
  parameter int IN_SETUP  = 25,
  parameter int IN_PULSE  = 319,
  parameter int IN_GAP    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_read,
  input  logic [ADDR_W-1:0] req_port,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              halt_req,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din,
  output logic              bus_out_stb,
  output logic              bus_in_stb,
  input  logic              bus_wait_in,
  output logic              bus_halt
);

  localparam int CNT_W = hiobus_pkg::span_width(OUT_PULSE, IN_SETUP, IN_PULSE, IN_GAP);

  logic             accept, tmr_load, tmr_zero, capture;
  logic             sample_evt, wait_seen;
  logic [CNT_W-1:0] tmr_val;

  hiobus_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  hiobus_ctrl #(
    .CNT_W     (CNT_W),
    .OUT_PULSE (OUT_PULSE),
    .IN_SETUP  (IN_SETUP),
    .IN_PULSE  (IN_PULSE),
    .IN_GAP    (IN_GAP)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_is_read (req_is_read),
    .halt_req    (halt_req),
    .bus_wait_in (bus_wait_in),
    .tmr_zero    (tmr_zero),
    .req_ready   (req_ready),
    .accept      (accept),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .out_stb     (bus_out_stb),
    .in_stb      (bus_in_stb),
    .capture     (capture),
    .done        (done),
    .busy        (busy),
    .halted      (bus_halt),
    .wait_sample (sample_evt),
    .wait_seen   (wait_seen)
  );

  hiobus_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .req_is_read (req_is_read),
    .req_port    (req_port),
    .req_wdata   (req_wdata),
    .capture     (capture),
    .bus_din     (bus_din),
    .bus_addr    (bus_addr),
    .bus_dout    (bus_dout),
    .rd_data     (rd_data)
  );

endmodule

// File: rtl/hiobus_seq_chk.sv
`timescale 1ns/1ps
module hiobus_seq_chk #(
  parameter int ADDR_W    = 8,
  parameter int OUT_PULSE = 94,
  parameter int IN_PULSE  = 319
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_out_stb,
  input logic              bus_in_stb,
  input logic              bus_halt,
  input logic              sample_evt,
  input logic              wait_seen
);

  int out_hi, in_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_hi <= 0;
      in_hi  <= 0;
    end else begin
      out_hi <= bus_out_stb ? out_hi + 1 : 0;
      in_hi  <= bus_in_stb  ? in_hi + 1  : 0;
    end
  end

  assert_ready_only_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);

  assert_out_no_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_out_stb) |-> $rose(busy));

  assert_out_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_out_stb) |-> (out_hi == OUT_PULSE));

  assert_in_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_in_stb) |-> (in_hi == IN_PULSE));

  assert_wait_before_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_in_stb) |-> $past(sample_evt));

  assert_repeat_or_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_in_stb) |-> (done == !wait_seen));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_halt |=> bus_halt);

  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_halt |-> (!busy && !req_ready));

  assert_addr_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(bus_addr));

  assert_strobes_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_out_stb && bus_in_stb));

  assert_strobes_in_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_out_stb && !bus_in_stb));

endmodule

bind hiobus_seq hiobus_seq_chk #(
  .ADDR_W    (ADDR_W),
  .OUT_PULSE (OUT_PULSE),
  .IN_PULSE  (IN_PULSE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .busy        (busy),
  .done        (done),
  .bus_addr    (bus_addr),
  .bus_out_stb (bus_out_stb),
  .bus_in_stb  (bus_in_stb),
  .bus_halt    (bus_halt),
  .sample_evt  (sample_evt),
  .wait_seen   (wait_seen)
);

// File: tb/hiobus_seq_test.sv
`timescale 1ns/1ps
module hiobus_seq_test;

  localparam int T_OUT   = 7;
  localparam int T_SETUP = 3;
  localparam int T_IN    = 9;
  localparam int T_GAP   = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_is_read = 1'b0, halt_req = 1'b0;
  logic [7:0] req_port = '0, req_wdata = '0, bus_din = '0;
  logic       bus_wait_in = 1'b0;
  logic       req_ready, busy, done, bus_out_stb, bus_in_stb, bus_halt;
  logic [7:0] rd_data, bus_addr, bus_dout;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  hiobus_seq #(
    .OUT_PULSE (T_OUT),
    .IN_SETUP  (T_SETUP),
    .IN_PULSE  (T_IN),
    .IN_GAP    (T_GAP)
  ) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_is_read (req_is_read),
    .req_port    (req_port),
    .req_wdata   (req_wdata),
    .halt_req    (halt_req),
    .busy        (busy),
    .done        (done),
    .rd_data     (rd_data),
    .bus_addr    (bus_addr),
    .bus_dout    (bus_dout),
    .bus_din     (bus_din),
    .bus_out_stb (bus_out_stb),
    .bus_in_stb  (bus_in_stb),
    .bus_wait_in (bus_wait_in),
    .bus_halt    (bus_halt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!bus_out_stb && !bus_in_stb, "R10 strobes", {bus_out_stb, bus_in_stb}, 0);
    chk(!busy && !done && !bus_halt, "R10 busy/done/halt", {busy, done, bus_halt}, 0);
    chk(bus_addr == 0 && rd_data == 0, "R10 addr/rd_data", {bus_addr, rd_data}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R10 ready after reset", req_ready, 1);
    chk(!busy, "R10 idle after reset", busy, 0);
  endtask

  task automatic t_write(input logic [7:0] port, input logic [7:0] data);
    int w;
    chk(req_ready, "R1 ready when idle", req_ready, 1);
    req_valid = 1'b1; req_is_read = 1'b0; req_port = port; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && bus_out_stb, "R2 strobe with busy", {busy, bus_out_stb}, 3);
    chk(bus_addr == port, "R2 address", bus_addr, port);
    chk(bus_dout == data, "R2 data", bus_dout, data);
    chk(!bus_halt, "R9 status low in cycle", bus_halt, 0);
    w = 1;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (!bus_out_stb) break;
      w++;
    end
    chk(w == T_OUT, "R3 output strobe width", w, T_OUT);
    chk(done && !busy, "R8 done as busy falls", {done, busy}, 2);
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);
  endtask

  // Peripheral model: wait held for nwait strobes, data = base + strobe index.
  task automatic t_read(input logic [7:0] port, input int nwait, input logic [7:0] base);
    int pulses, setup, hi, lo;
    bit prev, fin;
    bus_din = base; bus_wait_in = (nwait > 0);
    req_valid = 1'b1; req_is_read = 1'b1; req_port = port;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && bus_addr == port, "R4 address driven at accept", bus_addr, port);
    chk(!bus_in_stb, "R4 no strobe at address edge", bus_in_stb, 0);
    pulses = 0; setup = 1; hi = 0; lo = 0; prev = 1'b0; fin = 1'b0;
    for (int i = 0; i < 5000 && !fin; i++) begin
      @(negedge clk);
      if (bus_out_stb) chk(0, "R11 output strobe during read", 1, 0);
      if (busy) chk(bus_addr == port, "R11 address held", bus_addr, port);
      if (bus_in_stb) begin
        if (!prev) begin
          if (pulses == 0) chk(setup == T_SETUP, "R4 address to strobe", setup, T_SETUP);
          else             chk(lo == T_GAP, "R6 gap between strobes", lo, T_GAP);
          hi = 1;
        end else hi++;
      end else begin
        if (prev) begin
          chk(hi == T_IN, "R5 input strobe width", hi, T_IN);
          pulses++;
          bus_wait_in = (pulses < nwait);
          bus_din = base + 8'(pulses);
          lo = 1;
        end else if (pulses == 0) setup++;
        else lo++;
      end
      prev = bus_in_stb;
      if (done) fin = 1'b1;
    end
    chk(fin && !busy, "R8 done ends read", {fin, busy}, 2);
    chk(pulses == nwait + 1, "R6 strobe count", pulses, nwait + 1);
    chk(rd_data == base + 8'(nwait), "R7 final byte", rd_data, base + 8'(nwait));
    bus_wait_in = 1'b0;
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);
    chk(rd_data == base + 8'(nwait), "R7 result held", rd_data, base + 8'(nwait));
  endtask

  task automatic t_hold();
    bit ready_seen;
    req_valid = 1'b1; req_is_read = 1'b0; req_port = 8'd254; req_wdata = 8'h11;
    @(negedge clk);
    req_port = 8'd253; req_wdata = 8'h22;
    ready_seen = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      if (!bus_out_stb) break;
      if (req_ready) ready_seen = 1'b1;
      if (bus_addr != 8'd254) chk(0, "R11 address held while busy", bus_addr, 254);
      @(negedge clk);
    end
    chk(!ready_seen, "R1 no ready while busy", ready_seen, 0);
    chk(req_ready && done, "R1 ready at completion", {req_ready, done}, 3);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && bus_out_stb, "R1 held request taken", {busy, bus_out_stb}, 3);
    chk(bus_addr == 8'd253 && bus_dout == 8'h22, "R1 held request fields", bus_addr, 253);
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (!bus_out_stb) break;
    end
    @(negedge clk);
  endtask

  task automatic t_halt();
    bit moved;
    logic [7:0] addr0;
    addr0 = bus_addr;
    halt_req = 1'b1;
    @(negedge clk);
    halt_req = 1'b0;
    chk(!bus_halt, "R9 status not yet high", bus_halt, 0);
    @(negedge clk);
    chk(bus_halt, "R9 status high two edges on", bus_halt, 1);
    chk(!req_ready, "R9 ready low when halted", req_ready, 0);
    req_valid = 1'b1; req_is_read = 1'b0; req_port = 8'h42; req_wdata = 8'h99;
    moved = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (busy || bus_out_stb || bus_addr != addr0 || !bus_halt) moved = 1'b1;
    end
    req_valid = 1'b0;
    chk(!moved, "R9 requests refused while halted", moved, 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_write(8'd255, 8'hFF);
    t_write(8'd253, 8'h5A);
    t_read(8'd255, 0, 8'h30);
    t_read(8'd252, 1, 8'h70);
    t_read(8'h10, 3, 8'hC0);
    t_hold();
    t_read(8'd254, 2, 8'h05);
    t_halt();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule